// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block sits between clocked on-chip logic and an external static RAM whose pins are not clocked. The internal side issues one single-word read or write at a time. The controller turns each request into a timed sequence of chip select, write strobe, output enable and data-bus direction. All outputs come from registers, so the external pins do not glitch.

The setup, strobe/access and hold windows are counted in clock cycles. Three parameters set them, and each must be at least 1. For writes, the address and data are placed on the pins before the strobes fall, and they stay there after the strobes rise. For reads, the bus is released before the memory is asked to drive it. After every transaction there is one quiet cycle in which nothing drives the bus. A one-cycle completion pulse marks that cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `rsp_done` is 0.
- R2: When a write (`req_write`=1) is accepted in idle, the first T_SETUP cycles present the request address on `mem_addr` and the request data on `mem_dq_out`, with `mem_dq_oe`=1 and all three strobes at 1.
- R3: The write strobe window follows. It lasts T_ACCESS cycles with `mem_cs_n`=0, `mem_we_n`=0, `mem_oe_n`=1, the bus driven, and address and data unchanged.
- R4: After the write strobe rises, the address and data stay on the pins and the bus stays driven for T_HOLD cycles, with all strobes at 1.
- R5: An accepted read (`req_write`=0) holds `mem_cs_n`=0 and `mem_oe_n`=0 for T_ACCESS+1 cycles, with `mem_we_n`=1, the bus undriven and the address fixed. `rsp_rdata` takes the value of `mem_dq_in` at the clock edge that closes the last of those cycles.
- R6: `mem_we_n` and `mem_oe_n` are never 0 in the same cycle, and `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R7: Every transaction ends with one turnaround cycle in which all strobes are 1, `mem_dq_oe` is 0 and `rsp_done` is 1. `rsp_done` is high for that single cycle only. Counting the cycle after the accepting edge as cycle 1, the done cycle is cycle T_SETUP+T_ACCESS+T_HOLD+1 for a write and cycle T_ACCESS+2 for a read.
- R8: A request presented while a transaction is in progress, up to and including its done cycle, is ignored. It changes no pin value and causes no extra write.
- R9: A request that is present from the done cycle onward is accepted at the end of the idle cycle that follows. Its first phase is therefore visible two cycles after the done cycle.
- R10: `rsp_rdata` keeps the most recently read word through writes and idle time, until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; sampled only in idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Data to write |
| rsp_rdata | output | DW | Last word read |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW | Address pins of the RAM |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DW | Value to drive onto the shared data bus |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | DW | Value seen on the shared data bus |

## Verification
The bench runs isolated writes and reads to distinct addresses and patterns. These show whether each phase has its own length, whether the phases follow in the right order, and whether data lands at the right address. The bench's memory model returns junk until the bus has been enabled for the full access window, so a capture one cycle early reads the wrong word. A request kept asserted with a different address and data during a transaction shows whether busy-time requests are ignored. A write followed at once by a read checks the idle gap and the bus turnaround. A write after a read checks that the read result is kept.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WSETUP   = 3'd1,
    ST_WPULSE   = 3'd2,
    ST_WHOLD    = 3'd3,
    ST_RACCESS  = 3'd4,
    ST_RCAPTURE = 3'd5,
    ST_TURN     = 3'd6
  } ctrl_state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
    logic done;
  } pin_ctl_t;

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // a phase loaded with N spends N cycles before this fires in its last cycle
  assign expired = (cnt == CW'(1));

endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_ctrl_pkg::*;
(
  input  ctrl_state_e st,
  output pin_ctl_t    pins
);

  always_comb begin
    pins = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, done: 1'b0};
    case (st)
      ST_WSETUP:   pins.dq_oe = 1'b1;
      ST_WPULSE: begin
        pins.cs_n  = 1'b0;
        pins.we_n  = 1'b0;
        pins.dq_oe = 1'b1;
      end
      ST_WHOLD:    pins.dq_oe = 1'b1;
      ST_RACCESS, ST_RCAPTURE: begin
        pins.cs_n = 1'b0;
        pins.oe_n = 1'b0;
      end
      ST_TURN:     pins.done = 1'b1;
      default:     ;
    endcase
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int T_SETUP  = 1,
  parameter int T_ACCESS = 2,
  parameter int T_HOLD   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int T_SA  = (T_SETUP > T_ACCESS) ? T_SETUP : T_ACCESS;
  localparam int T_MAX = (T_SA > T_HOLD) ? T_SA : T_HOLD;
  localparam int CW    = $clog2(T_MAX + 2);

  ctrl_state_e   state, state_nxt;
  pin_ctl_t      pins_nxt;
  logic [CW-1:0] phase_len;
  logic          phase_load;
  logic          phase_end;
  logic          accept;

  assign accept     = (state == ST_IDLE) && req_valid;
  assign phase_load = (state_nxt != state);

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:     if (req_valid) state_nxt = req_write ? ST_WSETUP : ST_RACCESS;
      ST_WSETUP:   if (phase_end) state_nxt = ST_WPULSE;
      ST_WPULSE:   if (phase_end) state_nxt = ST_WHOLD;
      ST_WHOLD:    if (phase_end) state_nxt = ST_TURN;
      ST_RACCESS:  if (phase_end) state_nxt = ST_RCAPTURE;
      ST_RCAPTURE: state_nxt = ST_TURN;
      ST_TURN:     state_nxt = ST_IDLE;
      default:     state_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_nxt)
      ST_WSETUP:            phase_len = CW'(T_SETUP);
      ST_WPULSE, ST_RACCESS: phase_len = CW'(T_ACCESS);
      ST_WHOLD:             phase_len = CW'(T_HOLD);
      default:              phase_len = CW'(1);
    endcase
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (phase_load),
    .load_val (phase_len),
    .expired  (phase_end)
  );

  sram_pin_decode u_decode (
    .st   (state_nxt),
    .pins (pins_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_cs_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      rsp_done   <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
    end else begin
      state      <= state_nxt;
      mem_cs_n   <= pins_nxt.cs_n;
      mem_we_n   <= pins_nxt.we_n;
      mem_oe_n   <= pins_nxt.oe_n;
      mem_dq_oe  <= pins_nxt.dq_oe;
      rsp_done   <= pins_nxt.done;
      if (accept) mem_addr <= req_addr;
      if (accept && req_write) mem_dq_out <= req_wdata;
      if (state == ST_RCAPTURE) rsp_rdata <= mem_dq_in;
    end
  end

  // R1: pins quiet right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done));

  // R2: strobe only falls after data and address were already on the pins
  assert_write_setup_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> ($past(mem_dq_oe) && $stable(mem_addr) && $stable(mem_dq_out)));

  // R3: write strobe always paired with chip select and a driven bus
  assert_write_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_cs_n && mem_dq_oe));

  // R4: address and data survive the rising strobe
  assert_write_hold_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));

  // R6: strobes exclusive, no contention while the RAM drives
  assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

  // R7: one-cycle done, bus released the cycle before the RAM may drive
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  assert_turnaround_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R8: address frozen while chip select stays low
  assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int TS = 2;
  localparam int TA = 3;
  localparam int TH = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_done;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  sram_async_ctrl #(.AW(AW), .DW(DW), .T_SETUP(TS), .T_ACCESS(TA), .T_HOLD(TH)) u_sram_async_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // RAM model: data valid only after TA enabled cycles
  logic [DW-1:0] ram [64];
  int            rd_age;
  int            wr_edges;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) ram[i] <= '0;
      rd_age   <= 0;
      wr_edges <= 0;
    end else begin
      if (!mem_cs_n && !mem_we_n) begin
        ram[mem_addr] <= mem_dq_out;
        wr_edges      <= wr_edges + 1;
      end
      rd_age <= (!mem_cs_n && !mem_oe_n) ? rd_age + 1 : 0;
    end
  end

  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && rd_age >= TA) ? ram[mem_addr] : 16'hBAD5;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-operation observations
  int n_setup, n_pulse, n_hold, n_read, n_cyc;
  bit addr_moved, data_moved, contention, turn_ok;

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit noisy);
    bit seen_pulse;
    n_setup = 0; n_pulse = 0; n_hold = 0; n_read = 0; n_cyc = 0;
    addr_moved = 0; data_moved = 0; contention = 0; turn_ok = 0; seen_pulse = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (noisy) begin
      req_write = 1'b1; req_addr = a ^ 6'h01; req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    for (int k = 0; k < 60; k++) begin
      n_cyc++;
      if (rsp_done) begin
        turn_ok = mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe;
        break;
      end
      if (mem_addr != a) addr_moved = 1;
      if (wr && mem_dq_out != d) data_moved = 1;
      if (mem_dq_oe && !mem_oe_n) contention = 1;
      if (!mem_cs_n && !mem_we_n && mem_oe_n && mem_dq_oe) begin
        n_pulse++; seen_pulse = 1;
      end else if (mem_cs_n && mem_we_n && mem_oe_n && mem_dq_oe) begin
        if (seen_pulse) n_hold++; else n_setup++;
      end else if (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_dq_oe) begin
        n_read++;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done, "R1 in reset",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done}, 5'b11100);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done, "R1 after reset",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done}, 5'b11100);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    do_op(1'b1, a, d, 1'b0);
    chk(n_setup == TS, "R2 setup cycles", n_setup, TS);
    chk(n_pulse == TA, "R3 strobe cycles", n_pulse, TA);
    chk(n_hold == TH, "R4 hold cycles", n_hold, TH);
    chk(!addr_moved && !data_moved, "R3 addr/data stable", {addr_moved, data_moved}, 0);
    chk(n_cyc == TS + TA + TH + 1, "R7 write done cycle", n_cyc, TS + TA + TH + 1);
    chk(turn_ok, "R7 turnaround pins", turn_ok, 1);
    @(negedge clk);
    chk(!rsp_done, "R7 done single cycle", rsp_done, 0);
    chk(ram[a] == d, "R3 word stored", ram[a], d);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    do_op(1'b0, a, '0, 1'b0);
    chk(n_read == TA + 1, "R5 read window", n_read, TA + 1);
    chk(!contention, "R6 no drive during read", contention, 0);
    chk(!addr_moved, "R5 addr stable", addr_moved, 0);
    chk(n_cyc == TA + 2, "R7 read done cycle", n_cyc, TA + 2);
    chk(rsp_rdata == exp, "R5 read data", rsp_rdata, exp);
    chk(turn_ok, "R7 read turnaround", turn_ok, 1);
    @(negedge clk);
    chk(!rsp_done, "R7 read done single", rsp_done, 0);
  endtask

  task automatic t_ignore_busy();
    int w0;
    w0 = wr_edges;
    do_op(1'b1, 6'h10, 16'h1357, 1'b1);
    chk(!addr_moved && !data_moved, "R8 busy request no pin change", {addr_moved, data_moved}, 0);
    chk(wr_edges - w0 == TA, "R8 no extra write", wr_edges - w0, TA);
    @(negedge clk);
    chk(mem_cs_n && mem_we_n && !mem_dq_oe, "R8 idle after ignored request",
        {mem_cs_n, mem_we_n, mem_dq_oe}, 3'b110);
    t_read(6'h11, 16'h2468);
  endtask

  task automatic t_back_to_back();
    do_op(1'b1, 6'h22, 16'h0F0F, 1'b0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'h22;
    @(negedge clk);
    chk(mem_cs_n && mem_oe_n && !mem_dq_oe, "R9 idle gap", {mem_cs_n, mem_oe_n, mem_dq_oe}, 3'b110);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_cs_n && !mem_oe_n && !mem_dq_oe, "R9 read starts", {mem_cs_n, mem_oe_n, mem_dq_oe}, 3'b000);
    for (int k = 0; k < 20 && !rsp_done; k++) @(negedge clk);
    chk(rsp_rdata == 16'h0F0F, "R9 back-to-back data", rsp_rdata, 16'h0F0F);
  endtask

  task automatic t_rdata_hold();
    t_read(6'h05, 16'hA5C3);
    do_op(1'b1, 6'h06, 16'h7777, 1'b0);
    chk(rsp_rdata == 16'hA5C3, "R10 rdata kept over write", rsp_rdata, 16'hA5C3);
    repeat (3) @(negedge clk);
    chk(rsp_rdata == 16'hA5C3, "R10 rdata kept in idle", rsp_rdata, 16'hA5C3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_write(6'h05, 16'hA5C3);
    t_write(6'h3F, 16'hFFFF);
    t_write(6'h00, 16'h0001);
    t_write(6'h11, 16'h2468);
    t_read(6'h3F, 16'hFFFF);
    t_read(6'h00, 16'h0001);
    t_read(6'h05, 16'hA5C3);
    t_ignore_busy();
    t_back_to_back();
    t_rdata_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule